// File: doc/BRIEF.md
# Five-Level Cascaded Bridge Modulator

This block produces the gate commands for a single-phase inverter made of two full-bridge cells in series. Each cell adds +1, 0 or -1 units of its DC supply, so the load sees one of five levels, from -2 to +2 units. A sinusoid-shaped reference is built inside the block, scaled by a modulation index, and compared against four triangular carriers. The carriers are stacked in adjacent vertical bands. The number of carriers lying below the reference selects the target level. The level is then turned into eight switch commands: one upper and one lower device per leg, two legs per cell.

Four carrier arrangements can be selected: all bands in phase, the bands above zero mirrored against those below, bands alternating in phase, and an in-phase arrangement whose period is re-drawn at random at every carrier trough. The random period spreads the switching spectrum. The level code and the gate bits are both registered, so a new level reaches the pins only on a clock edge. With the default parameters, one carrier period is 128 clocks and one reference period is 40 carrier periods.

Top module: `chb5_pwm`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `level` is 0 and `gate` is 8'hF0: all upper devices are off and all lower devices are on.
- R2: `level` is a 3-bit two's-complement code. After each clock edge it equals the number of band carriers strictly below the reference, minus 2, with both values taken as they stood before that edge. `gate` updates on the same edge.
- R3: With `arr_sel`=0, the carrier steps once every PRE_NOM clocks. Its phase runs from 0 to 2·BAND-1 and starts at 0 after reset. The offset equals the phase below BAND and equals 2·BAND minus the phase otherwise. Band k (0..3) has carrier (k-2)·BAND plus the offset.
- R4: With `arr_sel`=1, bands 2 and 3 use (k-2)·BAND + BAND - offset, and bands 0 and 1 use the R3 form.
- R5: With `arr_sel`=2, bands 1 and 3 use the inverted form of R4, and bands 0 and 2 use the R3 form.
- R6: With `arr_sel`=3, the bands are arranged as in R3. At each phase wrap, the step length becomes PRE_NOM-PRE_NOM/4 + (L mod (PRE_NOM/2+1)), where L is a 16-bit shift register. L is seeded to 16'hACE1, shifts right on every wrap in all modes, and is XORed with 16'hB400 when the bit shifted out is 1. In the other modes every wrap reloads PRE_NOM.
- R7: The reference phase p (0..REF_STEPS-1) advances every 2·BAND·PRE_NOM·FREQ_RATIO/REF_STEPS clocks. With h=REF_STEPS/2 and q=p mod h, the magnitude is floor(floor(8·BAND·q·(h-q)/h²)·m/2^MIW), where m is `mod_index` read as an unsigned Q1.MIW value. The magnitude is negated for p ≥ h.
- R8: `gate[3:0]` holds the upper devices in the order {cell 2 right, cell 2 left, cell 1 right, cell 1 left}. The values are +2 → 0101, +1 → 0001, 0 → 0000, -1 → 0010, -2 → 1010.
- R9: `gate[7:4]` holds the lower devices in the same leg order, and each bit is the complement of the upper bit on its leg.
- R10: Both upper devices of one cell are never on together.
- R11: A `mod_index` above 1.0 (2^MIW) behaves exactly as 1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arr_sel | input | 2 | Carrier arrangement: 0 in phase, 1 mirrored, 2 alternating, 3 random period |
| mod_index | input | MIW+1 | Modulation index, unsigned Q1.MIW |
| gate | output | 8 | Lower device commands [7:4], upper device commands [3:0] |
| level | output | 3 | Current output level, two's complement, -2..+2 |

## Verification
The assertions on the step length and on its hold between troughs assume `arr_sel` is a legal code and that reset starts every run. The period-hold property also assumes that the arrangement does not change in the middle of a carrier period. The stimulus therefore applies reset before each run and holds `arr_sel` and `mod_index` constant for the whole run. Each run spans a full reference period. The bench sweeps all four arrangements at indices from 0.6 to an over-range value. It predicts every cycle's level and gate pattern from the stated arithmetic, including the shift-register sequence used in random mode.

// File: rtl/chb5_pkg.sv
package chb5_pkg;

   typedef enum logic [1:0] {
      ARR_SAME      = 2'd0,
      ARR_MIRROR    = 2'd1,
      ARR_ALTERNATE = 2'd2,
      ARR_RANDOM    = 2'd3
   } carrier_arr_e;

   localparam int NUM_BANDS = 4;

   typedef logic [2:0] level_t;

   // upper device pattern {c2_right, c2_left, c1_right, c1_left}
   function automatic logic [3:0] upper_pattern(level_t lv);
      case (lv)
         3'b010:  return 4'b0101;
         3'b001:  return 4'b0001;
         3'b111:  return 4'b0010;
         3'b110:  return 4'b1010;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic band_inverted(carrier_arr_e arr, int k);
      case (arr)
         ARR_MIRROR:    return (k >= NUM_BANDS / 2);
         ARR_ALTERNATE: return (k % 2) == 1;
         default:       return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/chb5_carrier.sv
module chb5_carrier
   import chb5_pkg::*;
#(
   parameter int          BAND      = 16,
   parameter int          PRE_NOM   = 4,
   parameter bit          RANDOM_EN = 1'b1,
   parameter logic [15:0] LFSR_SEED = 16'hACE1,
   localparam int         BW        = $clog2(BAND + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rnd_mode,
   output logic [BW-1:0] tri_val
);
   localparam int PMIN  = PRE_NOM - PRE_NOM / 4;
   localparam int PSPAN = (PRE_NOM / 4) * 2 + 1;
   localparam int PMAX  = PMIN + PSPAN - 1;
   localparam int PLW   = $clog2(PMAX + 1);
   localparam int CPW   = $clog2(2 * BAND);

   logic [PLW-1:0] pre_cnt, pre_len, pre_next;
   logic [CPW-1:0] cph;
   logic           tick, wrap;

   assign tick = (pre_cnt == pre_len - PLW'(1));
   assign wrap = tick && (cph == CPW'(2 * BAND - 1));

   generate
      if (RANDOM_EN) begin : g_rand
         logic [15:0] lfsr;
         always_ff @(posedge clk) begin
            if (rst)
               lfsr <= LFSR_SEED;
            else if (wrap)
               lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
         end
         always_comb begin
            if (rnd_mode)
               pre_next = PLW'(32'(PMIN) + (32'(lfsr) % 32'(PSPAN)));
            else
               pre_next = PLW'(PRE_NOM);
         end
      end else begin : g_fixed
         assign pre_next = PLW'(PRE_NOM);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pre_cnt <= '0;
         pre_len <= PLW'(PRE_NOM);
         cph     <= '0;
      end else if (tick) begin
         pre_cnt <= '0;
         if (wrap) begin
            cph     <= '0;
            pre_len <= pre_next;
         end else begin
            cph <= cph + CPW'(1);
         end
      end else begin
         pre_cnt <= pre_cnt + PLW'(1);
      end
   end

   always_comb begin
      if (cph < CPW'(BAND))
         tri_val = BW'(cph);
      else
         tri_val = BW'(2 * BAND - int'(cph));
   end

   p_len_bounds_r6: assert property (@(posedge clk) disable iff (rst)
      (pre_len >= PLW'(PMIN)) && (pre_len <= PLW'(PMAX)));

   p_len_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !$stable(pre_len) |-> $past(wrap));

   p_tri_range_r3: assert property (@(posedge clk) disable iff (rst)
      tri_val <= BW'(BAND));

   p_step_r3: assert property (@(posedge clk) disable iff (rst)
      (tick && !wrap) |=> (cph == $past(cph) + CPW'(1)));

endmodule

// File: rtl/chb5_reference.sv
module chb5_reference #(
   parameter int  REF_STEPS = 64,
   parameter int  REF_TICK  = 80,
   parameter int  PEAK      = 32,
   parameter int  MIW       = 8,
   localparam int VW        = $clog2(PEAK + 1) + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [MIW:0]         mod_index,
   output logic signed [VW-1:0] ref_val
);
   localparam int RPW  = $clog2(REF_STEPS);
   localparam int HALF = REF_STEPS / 2;
   localparam int HSH  = 2 * (RPW - 1);
   localparam int RTW  = $clog2(REF_TICK);
   localparam int ONE  = 1 << MIW;

   logic [RTW-1:0] rcnt;
   logic [RPW-1:0] rph;
   logic [31:0]    q, mag, mi, amp;

   always_ff @(posedge clk) begin
      if (rst) begin
         rcnt <= '0;
         rph  <= '0;
      end else if (rcnt == RTW'(REF_TICK - 1)) begin
         rcnt <= '0;
         rph  <= rph + RPW'(1);
      end else begin
         rcnt <= rcnt + RTW'(1);
      end
   end

   always_comb begin
      q   = 32'(rph[RPW-2:0]);
      mag = (32'(4 * PEAK) * q * (32'(HALF) - q)) >> HSH;
      mi  = (32'(mod_index) > 32'(ONE)) ? 32'(ONE) : 32'(mod_index);
      amp = (mag * mi) >> MIW;
      if (rph[RPW-1])
         ref_val = -$signed(VW'(amp));
      else
         ref_val = $signed(VW'(amp));
   end

   p_ref_peak_r7: assert property (@(posedge clk) disable iff (rst)
      (ref_val <= $signed(VW'(PEAK))) && (ref_val >= -$signed(VW'(PEAK))));

   p_ref_sign_r7: assert property (@(posedge clk) disable iff (rst)
      rph[RPW-1] |-> (ref_val <= 0));

endmodule

// File: rtl/chb5_compare.sv
module chb5_compare
   import chb5_pkg::*;
#(
   parameter int  BAND = 16,
   parameter int  VW   = 7,
   localparam int BW   = $clog2(BAND + 1)
) (
   input  carrier_arr_e         arr,
   input  logic [BW-1:0]        tri_val,
   input  logic signed [VW-1:0] ref_val,
   output level_t               level_next
);
   logic [NUM_BANDS-1:0] above;

   for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
      logic signed [VW-1:0] carrier;
      always_comb begin
         if (band_inverted(arr, k))
            carrier = VW'((k - 2) * BAND + BAND - int'(tri_val));
         else
            carrier = VW'((k - 2) * BAND + int'(tri_val));
      end
      assign above[k] = (ref_val > carrier);
   end

   assign level_next = level_t'(3'($countones(above)) - 3'd2);

endmodule

// File: rtl/chb5_gate_drive.sv
module chb5_gate_drive
   import chb5_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  level_t     level_next,
   output level_t     level_q,
   output logic [7:0] gate_q
);
   logic [3:0] up_next;

   assign up_next = upper_pattern(level_next);

   always_ff @(posedge clk) begin
      if (rst) begin
         level_q <= '0;
         gate_q  <= 8'hF0;
      end else begin
         level_q <= level_next;
         gate_q  <= {~up_next, up_next};
      end
   end

   p_reset_zero_r1: assert property (@(posedge clk)
      rst |=> (level_q == 3'b000) && (gate_q == 8'hF0));

   p_legs_compl_r9: assert property (@(posedge clk) disable iff (rst)
      gate_q[7:4] == ~gate_q[3:0]);

   p_cell_block_r10: assert property (@(posedge clk) disable iff (rst)
      !(gate_q[0] && gate_q[1]) && !(gate_q[2] && gate_q[3]));

   p_level_range_r2: assert property (@(posedge clk) disable iff (rst)
      ($signed(level_q) <= 3'sd2) && ($signed(level_q) >= -3'sd2));

   p_pos_sign_r8: assert property (@(posedge clk) disable iff (rst)
      gate_q[0] |-> ($signed(level_q) > 3'sd0));

   p_neg_sign_r8: assert property (@(posedge clk) disable iff (rst)
      gate_q[1] |-> ($signed(level_q) < 3'sd0));

endmodule

// File: rtl/chb5_pwm.sv
module chb5_pwm
   import chb5_pkg::*;
#(
   parameter int          BAND       = 16,
   parameter int          PRE_NOM    = 4,
   parameter int          FREQ_RATIO = 40,
   parameter int          REF_STEPS  = 64,
   parameter int          MIW        = 8,
   parameter bit          RANDOM_EN  = 1'b1,
   parameter logic [15:0] LFSR_SEED  = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [1:0]   arr_sel,
   input  logic [MIW:0] mod_index,
   output logic [7:0]   gate,
   output logic [2:0]   level
);
   localparam int PEAK     = 2 * BAND;
   localparam int CAR_CLKS = 2 * BAND * PRE_NOM;
   localparam int REF_TICK = CAR_CLKS * FREQ_RATIO / REF_STEPS;
   localparam int VW       = $clog2(PEAK + 1) + 1;
   localparam int BW       = $clog2(BAND + 1);

   if (BAND < 2) begin : g_chk_band
      $error("BAND must be at least 2");
   end
   if ((PRE_NOM < 4) || (PRE_NOM % 4 != 0)) begin : g_chk_pre
      $error("PRE_NOM must be a multiple of 4");
   end
   if ((REF_STEPS < 4) || ((REF_STEPS & (REF_STEPS - 1)) != 0)) begin : g_chk_steps
      $error("REF_STEPS must be a power of two, at least 4");
   end
   if (((CAR_CLKS * FREQ_RATIO) % REF_STEPS != 0) || (REF_TICK < 2)) begin : g_chk_tick
      $error("reference period must split evenly into REF_STEPS samples");
   end

   carrier_arr_e         arr;
   logic [BW-1:0]        tri_val;
   logic signed [VW-1:0] ref_val;
   level_t               level_next, level_q;
   logic [7:0]           gate_q;

   assign arr = carrier_arr_e'(arr_sel);

   chb5_carrier #(
      .BAND      (BAND),
      .PRE_NOM   (PRE_NOM),
      .RANDOM_EN (RANDOM_EN),
      .LFSR_SEED (LFSR_SEED)
   ) u_carrier (
      .clk      (clk),
      .rst      (rst),
      .rnd_mode (arr == ARR_RANDOM),
      .tri_val  (tri_val)
   );

   chb5_reference #(
      .REF_STEPS (REF_STEPS),
      .REF_TICK  (REF_TICK),
      .PEAK      (PEAK),
      .MIW       (MIW)
   ) u_reference (
      .clk       (clk),
      .rst       (rst),
      .mod_index (mod_index),
      .ref_val   (ref_val)
   );

   chb5_compare #(
      .BAND (BAND),
      .VW   (VW)
   ) u_compare (
      .arr        (arr),
      .tri_val    (tri_val),
      .ref_val    (ref_val),
      .level_next (level_next)
   );

   chb5_gate_drive u_gate (
      .clk        (clk),
      .rst        (rst),
      .level_next (level_next),
      .level_q    (level_q),
      .gate_q     (gate_q)
   );

   assign gate  = gate_q;
   assign level = level_q;

   p_gate_tracks_r2: assert property (@(posedge clk) disable iff (rst)
      (level_q == 3'b000) |-> (gate_q == 8'hF0));

endmodule

// File: tb/chb5_pwm_test.sv
module chb5_pwm_test;
   localparam int B    = 16;
   localparam int PN   = 4;
   localparam int RT   = 2 * B * PN * 40 / 64;
   localparam int RUN  = 2 * B * PN * 40;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] arr_sel = 2'd0;
   logic [8:0] mod_index = 9'd256;
   logic [7:0] gate;
   logic [2:0] level;

   int tests = 0;
   int fails = 0;

   // model state
   int          m_pc, m_pl, m_cph;
   logic [15:0] m_l;

   always #5 clk = ~clk;

   chb5_pwm uut (
      .clk       (clk),
      .rst       (rst),
      .arr_sel   (arr_sel),
      .mod_index (mod_index),
      .gate      (gate),
      .level     (level)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int upper_of(int lv);
      case (lv)
         2:       return 5;
         1:       return 1;
         -1:      return 2;
         -2:      return 10;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_level(int mode, int mi, int cph, int rph);
      int tri_v, q, mag, mis, amp, r, cnt, c;
      bit inv;
      tri_v = (cph < B) ? cph : 2 * B - cph;
      q     = rph % 32;
      mag   = (8 * B * q * (32 - q)) / 1024;
      mis   = (mi > 256) ? 256 : mi;
      amp   = (mag * mis) / 256;
      r     = (rph >= 32) ? -amp : amp;
      cnt   = 0;
      for (int k = 0; k < 4; k++) begin
         inv = (mode == 1) ? (k >= 2) : (mode == 2) ? (k % 2 == 1) : 1'b0;
         c   = (k - 2) * B + (inv ? B - tri_v : tri_v);
         if (r > c) cnt++;
      end
      return cnt - 2;
   endfunction

   task automatic run(input int mode, input int mi, input string req);
      int e, eu, lv;
      bit seen[5];
      arr_sel   = 2'(mode);
      mod_index = 9'(mi);
      rst       = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(level == 3'd0 && gate == 8'hF0, "R1 reset state", int'(gate), 240);
      rst  = 1'b0;
      m_pc = 0; m_pl = PN; m_cph = 0; m_l = 16'hACE1;
      foreach (seen[i]) seen[i] = 1'b0;
      for (int j = 0; j < RUN; j++) begin
         @(negedge clk);
         e  = exp_level(mode, mi, m_cph, (j / RT) % 64);
         eu = upper_of(e);
         lv = int'($signed(level));
         check(lv == e, req, lv, e);
         check(gate[3:0] == 4'(eu), "R8 upper pattern", int'(gate[3:0]), eu);
         check(gate[7:4] == ~gate[3:0], "R9 lower complement", int'(gate), eu);
         check(!(gate[0] && gate[1]) && !(gate[2] && gate[3]), "R10 cell block", int'(gate[3:0]), eu);
         if (lv >= -2 && lv <= 2) seen[lv + 2] = 1'b1;
         // advance model by one clock
         if (m_pc == m_pl - 1) begin
            m_pc = 0;
            if (m_cph == 2 * B - 1) begin
               m_cph = 0;
               m_pl  = (mode == 3) ? (3 + int'(m_l) % 3) : PN;
               m_l   = {1'b0, m_l[15:1]} ^ (m_l[0] ? 16'hB400 : 16'h0000);
            end else begin
               m_cph++;
            end
         end else begin
            m_pc++;
         end
      end
      if (mi >= 154)
         check(seen[0] && seen[4], "R2 extreme levels reached", int'(seen[4]), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      run(0, 256, "R3 in-phase R2");
      run(0, 154, "R7 index 0.6");
      run(1, 205, "R4 mirrored");
      run(2, 230, "R5 alternating");
      run(3, 256, "R6 random period");
      run(3, 180, "R6 random low index");
      run(0, 400, "R11 saturated index");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule